// File: doc/BRIEF.md
# SDRAM Bank Write-Precharge Timing Tracker

This block watches a decoded SDRAM command stream and keeps, for each bank, a small state machine with its own down-counters. It follows every bank from row activation through write bursts and into precharge. The precharge may be requested explicitly, or it may start inside the bank on its own after a write that asked for automatic precharge. It does not store data or drive the memory. It judges each command against the row-to-column delay, the write recovery time, the minimum row-active time and the precharge time. It also tells the controller which banks would take an activation right now.

An illegal command is reported one cycle later on a single-cycle flag, together with the bank number, and it leaves that bank's state untouched. All four timings and the burst length are parameters counted in clock cycles. When automatic precharge is requested, the internal precharge is scheduled at the later of two points: the recovery point after the final data beat, and the end of the minimum active window. A per-bank pulse marks the cycle in which each precharge begins.

Top module: `sdram_wr_pch_tracker`

## Requirements
- R1: `cmd_i` is decoded as 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = burst stop. Codes 0, 6 and 7 carry no command and are never flagged.
- R2: After reset every bank is idle, `act_ready_o` is all ones, `viol_o` is low and `pch_start_o` is all zero.
- R3: A read or write to a bank fewer than TRCD cycles after that bank's activate is flagged. At exactly TRCD cycles it is accepted.
- R4: A write occupies BURST_LEN data beats, the first in the cycle of the write itself. A new write to the same bank during a burst without automatic precharge restarts the burst.
- R5: An explicit precharge is accepted only once TWR cycles have passed since the last data beat and TRAS cycles since the activate; otherwise it is flagged. An accepted one starts the bank's precharge in its own cycle.
- R6: An activate is accepted exactly when the bank's `act_ready_o` bit is high. That bit rises TRP cycles after the precharge start, and an activate issued earlier is flagged.
- R7: A write with `ap_i` high makes `pch_start_o` pulse for that bank in cycle max(last beat + TWR, activate + TRAS), and no earlier.
- R8: From an auto-precharging write until TRP cycles after its internal precharge starts, every read, write, precharge, burst stop or activate to that bank is flagged.
- R9: `viol_o` is high for one cycle, in the cycle after an illegal command, with `viol_bank_o` holding that command's bank. While `viol_o` is low, `viol_bank_o` is zero. An illegal command changes no bank state.
- R10: Banks are independent: commands to other banks are judged only by their own state, including while one bank is locked by automatic precharge.
- R11: A burst stop or read during a burst without automatic precharge ends the burst. The last beat is then the cycle before, and an explicit precharge becomes legal TWR cycles after that beat.
- R12: An activate to a bank that is not idle is flagged. A precharge to an idle bank is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Decoded command code (see R1) |
| bank_i | input | BANK_W | Bank addressed by the command |
| ap_i | input | 1 | Automatic-precharge request, used with a write |
| viol_o | output | 1 | One-cycle pulse after an illegal command |
| viol_bank_o | output | BANK_W | Bank of the flagged command, zero otherwise |
| act_ready_o | output | NUM_BANKS | Per bank: an activate would be accepted in this cycle |
| pch_start_o | output | NUM_BANKS | Per bank: a precharge begins in this cycle |

## Verification
The bench sets TRAS long enough that, for an early auto-precharging write, the active-time limit and not write recovery decides the internal precharge. It then sets up a second bank where recovery decides. A design that used only one of the two bounds would pulse too early in one of these cases. Precharges and activates are issued one cycle before and exactly at each limit. An off-by-one counter load shows up as a wrongly flagged or wrongly accepted command. The bench also issues reads, writes, stops and activates into a bank locked by automatic precharge, while commands go to other banks in the same window. A design that accepted a locked command would shift the later precharge pulse, and one that confused banks would flag the interleaved commands.

// File: rtl/wpt_pkg.sv
// Package: shared command codes and bank state encoding for the write/precharge
// timing tracker. Assumes the command decoder upstream uses the same codes.
package wpt_pkg;

    localparam logic [2:0] CMD_NOP   = 3'd0;
    localparam logic [2:0] CMD_ACT   = 3'd1;
    localparam logic [2:0] CMD_READ  = 3'd2;
    localparam logic [2:0] CMD_WRITE = 3'd3;
    localparam logic [2:0] CMD_PRE   = 3'd4;
    localparam logic [2:0] CMD_BST   = 3'd5;

    typedef enum logic [2:0] {
        BK_IDLE        = 3'd0,
        BK_ACTIVE      = 3'd1,
        BK_WRITING     = 3'd2,
        BK_WR_RECOVERY = 3'd3,
        BK_PRECHARGING = 3'd4
    } bank_state_e;

endpackage

// File: rtl/wpt_bank_fsm.sv
// Module: one bank's timing state machine.
// Tracks idle / active / writing / write recovery / precharging with its own
// down-counters. Judges the command aimed at this bank (sel_i) and applies it
// only when legal. Assumes every timing parameter is at least 1 cycle and that
// all counts fit in CNT_W bits.
module wpt_bank_fsm
    import wpt_pkg::*;
#(
    parameter int TRCD      = 3,
    parameter int TRAS      = 7,
    parameter int TWR       = 2,
    parameter int TRP       = 3,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic [2:0] cmd_i,
    input  logic       ap_i,
    output logic       legal_o,
    output logic       act_ok_o,
    output logic       pch_start_o
);

    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(TRCD - 1);
    localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(TRAS - 1);
    localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(TWR - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(TRP - 1);
    localparam logic [CNT_W-1:0] BL_LD  = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] CUT_LD = (TWR >= 2) ? CNT_W'(TWR - 2) : '0;
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rcd_q, rcd_d;
    logic [CNT_W-1:0] ras_q, ras_d;
    logic             ap_q, ap_d;

    logic c_act, c_rd, c_wr, c_pre, c_bst;
    logic cnt_zero, rcd_done, ras_done;
    logic cmd_legal, accept, auto_start, expl_start;

    // Purpose: split the command code into one-hot strobes and counter flags.
    always_comb begin
        c_act    = (cmd_i == CMD_ACT);
        c_rd     = (cmd_i == CMD_READ);
        c_wr     = (cmd_i == CMD_WRITE);
        c_pre    = (cmd_i == CMD_PRE);
        c_bst    = (cmd_i == CMD_BST);
        cnt_zero = (cnt_q == '0);
        rcd_done = (rcd_q == '0);
        ras_done = (ras_q == '0);
    end

    // Purpose: decide whether the command would be legal in the current state.
    always_comb begin
        unique case (state_q)
            BK_IDLE:        cmd_legal = c_act | c_pre;
            BK_ACTIVE:      cmd_legal = ((c_wr | c_rd) & rcd_done)
                                      | (c_pre & ras_done) | c_bst;
            BK_WRITING:     cmd_legal = !ap_q & (c_wr | c_rd | c_bst);
            BK_WR_RECOVERY: cmd_legal = !ap_q & (c_wr | c_rd | c_bst
                                      | (c_pre & cnt_zero & ras_done));
            BK_PRECHARGING: cmd_legal = (c_act & cnt_zero) | (c_pre & !ap_q);
            default:        cmd_legal = 1'b0;
        endcase
    end

    // Purpose: derive acceptance, precharge start and activate readiness.
    always_comb begin
        accept      = sel_i & cmd_legal;
        auto_start  = (state_q == BK_WR_RECOVERY) & ap_q & cnt_zero & ras_done;
        expl_start  = accept & c_pre
                    & ((state_q == BK_ACTIVE) | (state_q == BK_WR_RECOVERY));
        pch_start_o = auto_start | expl_start;
        legal_o     = cmd_legal;
        act_ok_o    = (state_q == BK_IDLE)
                    | ((state_q == BK_PRECHARGING) & cnt_zero);
    end

    // Purpose: next-state logic - timed progression, then accepted command.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ap_d    = ap_q;
        rcd_d   = rcd_done ? '0 : rcd_q - ONE;
        ras_d   = ras_done ? '0 : ras_q - ONE;

        unique case (state_q)
            BK_WRITING: begin
                if (cnt_q == ONE) begin
                    state_d = BK_WR_RECOVERY;
                    cnt_d   = WR_LD;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            BK_WR_RECOVERY: begin
                if (!cnt_zero) begin
                    cnt_d = cnt_q - ONE;
                end else if (ap_q) begin
                    if (ras_done) begin
                        state_d = BK_PRECHARGING;
                        cnt_d   = RP_LD;
                    end
                end else begin
                    state_d = BK_ACTIVE;
                end
            end
            BK_PRECHARGING: begin
                if (!cnt_zero) begin
                    cnt_d = cnt_q - ONE;
                end else begin
                    state_d = BK_IDLE;
                    ap_d    = 1'b0;
                end
            end
            default: ;
        endcase

        if (accept) begin
            if (c_act) begin
                state_d = BK_ACTIVE;
                cnt_d   = '0;
                rcd_d   = RCD_LD;
                ras_d   = RAS_LD;
                ap_d    = 1'b0;
            end else if (c_wr) begin
                ap_d = ap_i;
                if (BURST_LEN == 1) begin
                    state_d = BK_WR_RECOVERY;
                    cnt_d   = WR_LD;
                end else begin
                    state_d = BK_WRITING;
                    cnt_d   = BL_LD;
                end
            end else if ((c_rd | c_bst) && state_q == BK_WRITING) begin
                state_d = BK_WR_RECOVERY;
                cnt_d   = CUT_LD;
            end else if (expl_start) begin
                state_d = BK_PRECHARGING;
                cnt_d   = RP_LD;
                ap_d    = 1'b0;
            end
        end
    end

    // Purpose: state and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            rcd_q   <= '0;
            ras_q   <= '0;
            ap_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rcd_q   <= rcd_d;
            ras_q   <= ras_d;
            ap_q    <= ap_d;
        end
    end

endmodule

// File: rtl/wpt_viol_flag.sv
// Module: registers the violation pulse and the offending bank number.
// Assumes at most one command per cycle, so one bank number suffices.
module wpt_viol_flag #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              illegal_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              viol_o,
    output logic [BANK_W-1:0] viol_bank_o
);

    // Purpose: one-cycle flag with the bank, zero bank when quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o      <= 1'b0;
            viol_bank_o <= '0;
        end else begin
            viol_o      <= illegal_i;
            viol_bank_o <= illegal_i ? bank_i : '0;
        end
    end

endmodule

// File: rtl/sdram_wr_pch_tracker.sv
// Module: top of the write/precharge timing tracker.
// Routes each decoded command to its bank's state machine, collects the
// legality verdict and activate readiness, and registers violations.
// Assumes a single command per cycle and timings given in clock cycles (>= 1).
module sdram_wr_pch_tracker
    import wpt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int TRAS      = 7,
    parameter int TWR       = 2,
    parameter int TRP       = 3,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 ap_i,
    output logic                 viol_o,
    output logic [BANK_W-1:0]    viol_bank_o,
    output logic [NUM_BANKS-1:0] act_ready_o,
    output logic [NUM_BANKS-1:0] pch_start_o
);

    localparam int MAX_A = (TRCD > TRAS) ? TRCD : TRAS;
    localparam int MAX_B = (TWR > TRP) ? TWR : TRP;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > BURST_LEN) ? MAX_C : BURST_LEN;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic                 cmd_real;
    logic                 illegal;
    logic [NUM_BANKS-1:0] sel_vec;
    logic [NUM_BANKS-1:0] legal_vec;

    // Purpose: a real command is one of the five defined codes.
    always_comb begin
        cmd_real = (cmd_i >= CMD_ACT) && (cmd_i <= CMD_BST);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Purpose: address decode for this bank.
        always_comb begin
            sel_vec[b] = cmd_real && (bank_i == BANK_W'(b));
        end

        wpt_bank_fsm #(
            .TRCD      (TRCD),
            .TRAS      (TRAS),
            .TWR       (TWR),
            .TRP       (TRP),
            .BURST_LEN (BURST_LEN),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_i       (sel_vec[b]),
            .cmd_i       (cmd_i),
            .ap_i        (ap_i),
            .legal_o     (legal_vec[b]),
            .act_ok_o    (act_ready_o[b]),
            .pch_start_o (pch_start_o[b])
        );
    end

    // Purpose: a selected bank that refuses the command marks it illegal.
    always_comb begin
        illegal = |(sel_vec & ~legal_vec);
    end

    wpt_viol_flag #(
        .BANK_W (BANK_W)
    ) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .illegal_i   (illegal),
        .bank_i      (bank_i),
        .viol_o      (viol_o),
        .viol_bank_o (viol_bank_o)
    );

endmodule

// File: rtl/wpt_checker.sv
// Module: assertion checker bound to the tracker's ports.
// Assumes the command codes of R1.
module wpt_checker #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int TRP       = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_i,
    input logic [BANK_W-1:0]    bank_i,
    input logic                 viol_o,
    input logic [BANK_W-1:0]    viol_bank_o,
    input logic [NUM_BANKS-1:0] act_ready_o,
    input logic [NUM_BANKS-1:0] pch_start_o
);

    localparam logic [2:0] K_ACT = 3'd1;

    p_nocmd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0 || cmd_i > 3'd5) |=> !viol_o);

    p_act_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == K_ACT && act_ready_o[bank_i]) |=> !viol_o);

    p_act_claims_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == K_ACT && act_ready_o[bank_i]) |=> !act_ready_o[$past(bank_i)]);

    p_act_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == K_ACT && !act_ready_o[bank_i])
        |=> (viol_o && viol_bank_o == $past(bank_i)));

    p_flag_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> (viol_bank_o == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_pch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pch_start_o[b] |-> !act_ready_o[b]);
        if (TRP > 1) begin : g_long_rp
            p_pch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                pch_start_o[b] |=> !act_ready_o[b]);
        end
    end

endmodule

bind sdram_wr_pch_tracker wpt_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .TRP       (TRP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .viol_o      (viol_o),
    .viol_bank_o (viol_bank_o),
    .act_ready_o (act_ready_o),
    .pch_start_o (pch_start_o)
);

// File: tb/sdram_wr_pch_tracker_tb.sv
// Bench: scoreboard. The driver pushes the expected flag for each command; a
// monitor at the falling edge pops and compares. Direct checks cover readiness
// and precharge pulses.
module sdram_wr_pch_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int T_RCD = 3;
    localparam int T_RAS = 10;
    localparam int T_WR  = 2;
    localparam int T_RP  = 3;
    localparam int BL    = 4;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, BST = 3'd5;

    typedef struct {
        logic       v;
        logic [1:0] b;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = NOP;
    logic [1:0] bank_i = '0;
    logic       ap_i = 1'b0;
    logic       viol_o;
    logic [1:0] viol_bank_o;
    logic [NB-1:0] act_ready_o;
    logic [NB-1:0] pch_start_o;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_wr_pch_tracker #(
        .NUM_BANKS (NB), .TRCD (T_RCD), .TRAS (T_RAS),
        .TWR (T_WR), .TRP (T_RP), .BURST_LEN (BL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .bank_i (bank_i),
        .ap_i (ap_i), .viol_o (viol_o), .viol_bank_o (viol_bank_o),
        .act_ready_o (act_ready_o), .pch_start_o (pch_start_o)
    );

    // Drive one command for one cycle and queue the expected flag.
    task automatic issue(input logic [2:0] c, input int bk, input logic ap,
                         input logic ev, input string req);
        exp_t e;
        @(negedge clk);
        cmd_i = c; bank_i = 2'(bk); ap_i = ap;
        @(posedge clk);
        e.v = ev; e.b = ev ? 2'(bk) : 2'd0; e.req = req;
        q.push_back(e);
        #1;
        cmd_i = NOP; ap_i = 1'b0;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(NOP, 0, 1'b0, 1'b0, "R1");
    endtask

    task automatic chk_ready(input int bk, input logic exp, input string req);
        total++;
        if (act_ready_o[bk] !== exp) begin
            bad++;
            $display("FAIL %s act_ready[%0d] actual=%b expected=%b", req, bk,
                     act_ready_o[bk], exp);
        end
    endtask

    task automatic chk_pch(input logic [NB-1:0] exp, input string req);
        total++;
        if (pch_start_o !== exp) begin
            bad++;
            $display("FAIL %s pch_start actual=%b expected=%b", req,
                     pch_start_o, exp);
        end
    endtask

    // Monitor: compare the registered flag one cycle after each command.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (viol_o !== e.v || viol_bank_o !== e.b) begin
                bad++;
                $display("FAIL %s viol actual=%b/%0d expected=%b/%0d", e.req,
                         viol_o, viol_bank_o, e.v, e.b);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        total++;
        if (act_ready_o !== 4'hF || viol_o !== 1'b0 || pch_start_o !== 4'h0) begin
            bad++;
            $display("FAIL R2 reset actual=%h/%b/%h expected=f/0/0",
                     act_ready_o, viol_o, pch_start_o);
        end

        // Bank 0: R3 tRCD, R4 burst restart, R5 recovery, R6 tRP
        issue(ACT, 0, 0, 0, "R6");
        issue(WR,  0, 0, 1, "R3");
        issue(RD,  0, 0, 1, "R3");
        issue(WR,  0, 0, 0, "R3");
        nop(2);
        issue(WR,  0, 0, 0, "R4");
        nop(3);
        issue(PRE, 0, 0, 1, "R5");
        issue(PRE, 0, 0, 0, "R5");
        chk_ready(0, 1'b0, "R6");
        issue(ACT, 0, 0, 1, "R6");
        issue(ACT, 0, 0, 1, "R6");
        chk_ready(0, 1'b1, "R6");
        issue(ACT, 0, 0, 0, "R6");

        // Bank 1: R12 double activate, R5 tRAS on explicit precharge
        issue(ACT, 1, 0, 0, "R12");
        issue(ACT, 1, 0, 1, "R12");
        nop(7);
        issue(PRE, 1, 0, 1, "R5");
        issue(PRE, 1, 0, 0, "R5");
        issue(PRE, 2, 0, 0, "R12");
        chk_ready(2, 1'b1, "R12");

        // Bank 2: auto-precharge held back by tRAS (R7), lock (R8), R9, R1
        issue(ACT, 2, 0, 0, "R7");
        nop(2);
        issue(WR,  2, 1, 0, "R7");
        issue(WR,  2, 0, 1, "R8");
        issue(PRE, 2, 0, 1, "R8");
        issue(RD,  2, 0, 1, "R8");
        issue(BST, 2, 0, 1, "R8");
        chk_pch(4'b0000, "R7");
        issue(3'd7, 2, 0, 0, "R1");
        chk_pch(4'b0000, "R7");
        nop(1);
        chk_pch(4'b0100, "R7");
        chk_ready(2, 1'b0, "R9");
        nop(2);
        chk_ready(2, 1'b0, "R8");
        issue(ACT, 2, 0, 1, "R8");
        chk_ready(2, 1'b1, "R6");

        // Bank 3: auto-precharge set by recovery (R7), interleave (R10)
        issue(ACT, 3, 0, 0, "R7");
        nop(5);
        issue(WR,  3, 1, 0, "R7");
        issue(WR,  0, 0, 0, "R10");
        issue(ACT, 1, 0, 0, "R10");
        nop(1);
        chk_pch(4'b0000, "R7");
        nop(1);
        chk_pch(4'b1000, "R7");
        issue(ACT, 3, 0, 1, "R8");
        nop(1);
        chk_ready(3, 1'b0, "R6");
        nop(1);
        chk_ready(3, 1'b1, "R6");

        // Bank 1: burst cut short by stop and by read (R11)
        nop(6);
        issue(WR,  1, 0, 0, "R11");
        issue(BST, 1, 0, 0, "R11");
        issue(PRE, 1, 0, 0, "R11");
        nop(2);
        chk_ready(1, 1'b1, "R11");
        issue(ACT, 1, 0, 0, "R11");
        nop(9);
        issue(WR,  1, 0, 0, "R11");
        nop(1);
        issue(RD,  1, 0, 0, "R11");
        issue(PRE, 1, 0, 0, "R11");
        issue(3'd6, 1, 0, 0, "R1");
        nop(3);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule